// File: doc/BRIEF.md
# Lane-Split SIMD Vector Unit

This block is a SIMD execution unit that sits beside a scalar core. The core hands it 16-bit vector commands through a push port. The commands wait in an eight-entry queue, and the unit drains that queue without ever waiting on the core. Each command names an operation, a lane width and three registers. The registers come from a file of sixteen 128-bit vectors. A command treats its operands either as sixteen independent 8-bit lanes or as eight independent 16-bit lanes, and every lane is computed in parallel.

A small controller state machine sequences execution. It has three states:
- IDLE: nothing is executing.
- EXEC: one command holds its operands and its result is being formed.
- MUL_WAIT: the second clock of a multiply, whose lane products are registered before write-back.

The controller makes these transitions:
- IDLE goes to EXEC when the queue holds a command.
- EXEC goes to MUL_WAIT for a multiply.
- EXEC goes to EXEC, and MUL_WAIT goes to EXEC, when the write-back retires a command while the next one is popped in the same clock.
- EXEC goes to IDLE, and MUL_WAIT goes to IDLE, when the write-back retires a command and the queue is empty.

A result that is still being written is forwarded to the command being popped, so dependent commands may follow one another back to back. A separate read port exposes any register, so results can be inspected.

Top module: `vu_core`

## Requirements
- R1: The queue holds at most 8 commands, and `cmd_stall` is high exactly while 8 commands wait in it. A push made while `cmd_stall` is high is dropped and has no effect on any register.
- R2: Commands execute strictly in push order. A command pushed into an idle unit at clock edge t0 is popped at edge t0+1 and writes its destination at edge t0+2. Its destination keeps its old value until that write.
- R3: Command word layout, from the most significant bit down: bits [15:13] opcode, bit [12] lane width (0 = sixteen 8-bit lanes, 1 = eight 16-bit lanes), bits [11:8] destination register, bits [7:4] source A, bits [3:0] source B. Lane k occupies bits [k*W+W-1 : k*W] for lane width W.
- R4: After reset, `idle` is 1, `cmd_stall` is 0, and byte j of register r (bits [8j+7:8j]) holds (29*r + 7*j + 3) mod 256.
- R5: Opcode 0 is a lane-wise add and opcode 1 is a lane-wise subtract (A minus B). Both wrap modulo 2^W, and no carry or borrow crosses a lane boundary.
- R6: Opcode 2 is a saturating add and opcode 3 a saturating subtract, on signed two's-complement lanes. Opcode bit 1 selects saturation. A result beyond the lane range is clamped to -2^(W-1) or 2^(W-1)-1.
- R7: Opcode 4 writes the low W bits of the lane product A*B. A multiply takes two clocks, so it writes at edge t0+3 for a push at t0, and no command is popped during its first clock.
- R8: Opcodes 5, 6 and 7 shift each lane of A by the low log2(W) bits of the same lane of B. Opcode 5 shifts left, opcode 6 shifts right logically and opcode 7 shifts right arithmetically.
- R9: A command that reads a register written by the command just before it sees the new value, with no extra delay. This holds for a multiply as well.
- R10: `idle` is 1 exactly when the queue is empty and no command is in EXEC or MUL_WAIT. Once `idle` is 1, all accepted results are visible on the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered this clock |
| cmd_word | input | 16 | Command word, with the layout given in R3 |
| cmd_stall | output | 1 | Queue is full; an offered command is dropped |
| rd_idx | input | 4 | Register selected for inspection |
| rd_data | output | 128 | Current contents of the selected register |
| idle | output | 1 | Queue empty and nothing executing |

## Verification
Three things can fall into the same clock: the write-back of one command, the pop of the next command that reads that same register, and a push from the core. The bench provokes this with chains of back-to-back dependent commands, including a multiply followed by its consumer, and with a stream of multiplies pushed every clock. That stream drives the queue to full while pops and pushes interleave, and the bench predicts that the sixteenth push is the first to be refused. Every outcome is judged on the read port against a bench-side register model that applies only the pushes the bench saw accepted.

// File: rtl/vu_pkg.sv
package vu_pkg;

    localparam int VLEN   = 128;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OP_W   = 3;
    localparam int CMD_W  = OP_W + 1 + 3 * RIDX_W;
    localparam int NBYTE  = VLEN / 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDS = 3'd2,
        OP_SUBS = 3'd3,
        OP_MUL  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_SRA  = 3'd7
    } vop_e;

    typedef struct packed {
        vop_e              op;
        logic              wide;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] srca;
        logic [RIDX_W-1:0] srcb;
    } vcmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_MULW  = 2'd2
    } vstate_e;

    // Power-on byte pattern of the register file.
    function automatic logic [7:0] init_byte(input int r, input int j);
        int v;
        v = (r * 29 + j * 7 + 3) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/vu_cmd_queue.sv
module vu_cmd_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             take, give;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign take  = push && !full;
    assign give  = pop && !empty;
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (take) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (give) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({take, give})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            slots[wr_ptr] <= push_data;
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_full_push_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/vu_lane.sv
module vu_lane
    import vu_pkg::*;
#(
    parameter int LW = 8
) (
    input  vop_e          op,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] y
);
    localparam int SH_W = $clog2(LW);

    logic [LW-1:0]        sum, dif, prod, lim;
    logic signed [LW-1:0] a_s;
    logic [SH_W-1:0]      sh;
    logic                 ovf_add, ovf_sub;

    always_comb begin
        sum     = a + b;
        dif     = a - b;
        prod    = a * b;
        a_s     = a;
        sh      = b[SH_W-1:0];
        ovf_add = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
        ovf_sub = (a[LW-1] != b[LW-1]) && (dif[LW-1] != a[LW-1]);
        lim     = a[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = sum;
            OP_SUB:  y = dif;
            OP_ADDS: y = ovf_add ? lim : sum;
            OP_SUBS: y = ovf_sub ? lim : dif;
            OP_MUL:  y = prod;
            OP_SHL:  y = a << sh;
            OP_SHR:  y = a >> sh;
            OP_SRA:  y = a_s >>> sh;
        endcase
    end

endmodule

// File: rtl/vu_alu.sv
module vu_alu
    import vu_pkg::*;
#(
    parameter int VW = VLEN
) (
    input  vop_e          op,
    input  logic          wide,
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;
    localparam int N_NARROW = VW / NARROW_W;
    localparam int N_WIDE   = VW / WIDE_W;

    logic [VW-1:0] y_narrow, y_wide;

    for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
        vu_lane #(.LW(NARROW_W)) u_lane (
            .op (op),
            .a  (a[k*NARROW_W +: NARROW_W]),
            .b  (b[k*NARROW_W +: NARROW_W]),
            .y  (y_narrow[k*NARROW_W +: NARROW_W])
        );
    end

    for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
        vu_lane #(.LW(WIDE_W)) u_lane (
            .op (op),
            .a  (a[k*WIDE_W +: WIDE_W]),
            .b  (b[k*WIDE_W +: WIDE_W]),
            .y  (y_wide[k*WIDE_W +: WIDE_W])
        );
    end

    assign y = wide ? y_wide : y_narrow;

endmodule

// File: rtl/vu_regfile.sv
module vu_regfile
    import vu_pkg::*;
#(
    parameter int N  = NREG,
    parameter int VW = VLEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] widx,
    input  logic [VW-1:0]        wdata,
    input  logic [$clog2(N)-1:0] ra_idx,
    input  logic [$clog2(N)-1:0] rb_idx,
    input  logic [$clog2(N)-1:0] rx_idx,
    output logic [VW-1:0]        ra_data,
    output logic [VW-1:0]        rb_data,
    output logic [VW-1:0]        rx_data
);
    localparam int NB = VW / 8;

    logic [VW-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                for (int j = 0; j < NB; j++) begin
                    regs[r][j*8 +: 8] <= init_byte(r, j);
                end
            end
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rx_data = regs[rx_idx];

endmodule

// File: rtl/vu_core.sv
module vu_core
    import vu_pkg::*;
#(
    parameter int QDEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_stall,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [VLEN-1:0]   rd_data,
    output logic              idle
);
    vstate_e           state, state_d;
    logic [CMD_W-1:0]  q_head;
    vcmd_t             head, ex_cmd;
    logic              q_empty, q_full, pop;
    logic [VLEN-1:0]   rf_a, rf_b, opa_q, opb_q, alu_y, mul_q;
    logic [RIDX_W-1:0] mul_dst;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [VLEN-1:0]   wr_data;
    logic              ex_is_mul;

    assign head      = vcmd_t'(q_head);
    assign ex_is_mul = (ex_cmd.op == OP_MUL);

    vu_cmd_queue #(.W(CMD_W), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd_valid),
        .push_data (cmd_word),
        .pop       (pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    vu_regfile #(.N(NREG), .VW(VLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .widx    (wr_idx),
        .wdata   (wr_data),
        .ra_idx  (head.srca),
        .rb_idx  (head.srcb),
        .rx_idx  (rd_idx),
        .ra_data (rf_a),
        .rb_data (rf_b),
        .rx_data (rd_data)
    );

    vu_alu #(.VW(VLEN)) u_alu (
        .op   (ex_cmd.op),
        .wide (ex_cmd.wide),
        .a    (opa_q),
        .b    (opb_q),
        .y    (alu_y)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (!q_empty) state_d = ST_EXEC;
            ST_EXEC: begin
                if (ex_is_mul)     state_d = ST_MULW;
                else if (q_empty)  state_d = ST_IDLE;
                else               state_d = ST_EXEC;
            end
            ST_MULW: state_d = q_empty ? ST_IDLE : ST_EXEC;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller: pop and write-back
    always_comb begin
        pop     = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
        unique case (state)
            ST_IDLE: pop = !q_empty;
            ST_EXEC: begin
                if (!ex_is_mul) begin
                    wr_en   = 1'b1;
                    wr_idx  = ex_cmd.dst;
                    wr_data = alu_y;
                    pop     = !q_empty;
                end
            end
            ST_MULW: begin
                wr_en   = 1'b1;
                wr_idx  = mul_dst;
                wr_data = mul_q;
                pop     = !q_empty;
            end
            default: pop = 1'b0;
        endcase
    end

    // Operand capture with forwarding of the result being written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_cmd  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            mul_q   <= '0;
            mul_dst <= '0;
        end else begin
            if (pop) begin
                ex_cmd <= head;
                opa_q  <= (wr_en && (wr_idx == head.srca)) ? wr_data : rf_a;
                opb_q  <= (wr_en && (wr_idx == head.srcb)) ? wr_data : rf_b;
            end
            if ((state == ST_EXEC) && ex_is_mul) begin
                mul_q   <= alu_y;
                mul_dst <= ex_cmd.dst;
            end
        end
    end

    assign cmd_stall = q_full;
    assign idle      = (state == ST_IDLE) && q_empty;

    assert_mul_second_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EXEC) && ex_is_mul) |=> (state == ST_MULW));

    assert_mul_holds_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EXEC) && ex_is_mul) |-> !pop);

    assert_forward_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && wr_en && (wr_idx == head.srca)) |=> (opa_q == $past(wr_data)));

    assert_forward_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && wr_en && (wr_idx == head.srcb)) |=> (opb_q == $past(wr_data)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!wr_en && !pop));

endmodule

// File: tb/sim_vu_core.sv
`timescale 1ns/1ps
module sim_vu_core;
    import vu_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [CMD_W-1:0]  cmd_word = '0;
    logic              cmd_stall;
    logic [RIDX_W-1:0] rd_idx = '0;
    logic [VLEN-1:0]   rd_data;
    logic              idle;

    int n_chk = 0;
    int n_bad = 0;
    logic [VLEN-1:0] mdl [NREG];

    always #2.5 clk = ~clk;

    vu_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd_stall (cmd_stall),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .idle      (idle)
    );

    function automatic logic [CMD_W-1:0] enc(int op, int wide, int d, int a, int b);
        return {3'(op), 1'(wide), 4'(d), 4'(a), 4'(b)};
    endfunction

    function automatic string req_of(int op);
        if (op < 2) return "R5";
        if (op < 4) return "R6";
        if (op == 4) return "R7";
        return "R8";
    endfunction

    function automatic logic [VLEN-1:0] calc(int op, int wide, logic [VLEN-1:0] a, logic [VLEN-1:0] b);
        logic [VLEN-1:0] res;
        int lw;
        longint mask, ua, ub, sa, sb, r, lo, hi;
        res  = '0;
        lw   = wide ? 16 : 8;
        mask = (longint'(1) << lw) - 1;
        lo   = -(longint'(1) << (lw - 1));
        hi   = (longint'(1) << (lw - 1)) - 1;
        for (int k = 0; k < VLEN / lw; k++) begin
            ua = longint'((a >> (k * lw)) & VLEN'(mask));
            ub = longint'((b >> (k * lw)) & VLEN'(mask));
            sa = (ua > hi) ? ua - (mask + 1) : ua;
            sb = (ub > hi) ? ub - (mask + 1) : ub;
            case (op)
                0: r = ua + ub;
                1: r = ua - ub;
                2: begin r = sa + sb; if (r > hi) r = hi; if (r < lo) r = lo; end
                3: begin r = sa - sb; if (r > hi) r = hi; if (r < lo) r = lo; end
                4: r = ua * ub;
                5: r = ua << (ub % lw);
                6: r = ua >> (ub % lw);
                default: r = sa >>> (ub % lw);
            endcase
            res = res | (VLEN'(r & mask) << (k * lw));
        end
        return res;
    endfunction

    task automatic chk_vec(string req, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer one command; returns whether it was accepted and updates the model.
    task automatic issue(logic [CMD_W-1:0] w, output bit acc);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        acc       = !cmd_stall;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (acc) mdl[w[11:8]] = calc(int'(w[15:13]), int'(w[12]), mdl[w[7:4]], mdl[w[3:0]]);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (idle) break;
        end
    endtask

    task automatic peek(int r, output logic [VLEN-1:0] v);
        @(negedge clk);
        rd_idx = RIDX_W'(r);
        #0.5;
        v = rd_data;
    endtask

    task automatic check_all(string req);
        logic [VLEN-1:0] v;
        for (int r = 0; r < NREG; r++) begin
            peek(r, v);
            chk_vec(req, $sformatf("register %0d", r), v, mdl[r]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit acc;
        logic [VLEN-1:0] v, old;
        int first_refused;
        void'($urandom(32'h5eed_1234));

        for (int r = 0; r < NREG; r++)
            for (int j = 0; j < NBYTE; j++)
                mdl[r][j*8 +: 8] = 8'((r * 29 + j * 7 + 3) % 256);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state of flags and register file
        chk_bit("R4", "idle after reset", idle, 1'b1);
        chk_bit("R4", "stall after reset", cmd_stall, 1'b0);
        check_all("R4");

        // R2/R10: exact latency of a plain add into register 1
        @(negedge clk);
        rd_idx = 4'd1;
        old = mdl[1];
        issue(enc(0, 0, 1, 2, 3), acc);
        @(negedge clk);
        chk_bit("R10", "idle one clock after push", idle, 1'b0);
        chk_vec("R2", "dst before pop", rd_data, old);
        @(negedge clk);
        chk_bit("R10", "idle while executing", idle, 1'b0);
        chk_vec("R2", "dst before write-back", rd_data, old);
        @(negedge clk);
        chk_bit("R10", "idle after write-back", idle, 1'b1);
        chk_vec("R2", "dst at write-back", rd_data, mdl[1]);

        // R7: multiply takes one clock more
        rd_idx = 4'd6;
        old = mdl[6];
        issue(enc(4, 1, 6, 1, 5), acc);
        @(negedge clk);
        chk_bit("R7", "idle after mul push", idle, 1'b0);
        @(negedge clk);
        chk_vec("R7", "mul dst first clock", rd_data, old);
        @(negedge clk);
        chk_bit("R7", "idle in second mul clock", idle, 1'b0);
        chk_vec("R7", "mul dst second clock", rd_data, old);
        @(negedge clk);
        chk_bit("R7", "idle after mul write", idle, 1'b1);
        chk_vec("R7", "mul result", rd_data, mdl[6]);

        // R5 R6 R7 R8: every opcode in both lane widths (R3 layout)
        for (int rep = 0; rep < 3; rep++) begin
            for (int op = 0; op < 8; op++) begin
                for (int wd = 0; wd < 2; wd++) begin
                    int d;
                    d = int'($urandom_range(15, 0));
                    issue(enc(op, wd, d, int'($urandom_range(15, 0)), int'($urandom_range(15, 0))), acc);
                    wait_idle();
                    peek(d, v);
                    chk_vec(req_of(op), $sformatf("op %0d wide %0d dst %0d", op, wd, d), v, mdl[d]);
                end
            end
        end

        // R9: back-to-back dependent commands, including after a multiply
        issue(enc(0, 0, 9, 3, 4), acc);
        issue(enc(2, 1, 10, 9, 9), acc);
        issue(enc(4, 0, 11, 10, 9), acc);
        issue(enc(1, 1, 12, 11, 10), acc);
        issue(enc(7, 0, 12, 12, 11), acc);
        issue(enc(4, 1, 13, 12, 12), acc);
        issue(enc(4, 1, 13, 13, 12), acc);
        issue(enc(3, 0, 14, 13, 13), acc);
        wait_idle();
        check_all("R9");

        // R1: stream of multiplies every clock; first refusal is the 16th push
        first_refused = -1;
        for (int i = 0; i < 24; i++) begin
            issue(enc(4, i % 2, 4 + (i % 12), int'($urandom_range(15, 0)), int'($urandom_range(15, 0))), acc);
            if (!acc && first_refused < 0) first_refused = i;
        end
        chk_int("R1", "index of first refused push", first_refused, 15);
        wait_idle();
        chk_bit("R1", "stall released when drained", cmd_stall, 1'b0);
        check_all("R1");

        // R2: random stream with gaps, checked against the in-order model
        for (int blk = 0; blk < 6; blk++) begin
            for (int i = 0; i < 60; i++) begin
                issue(enc(int'($urandom_range(7, 0)), int'($urandom_range(1, 0)),
                          int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
                          int'($urandom_range(15, 0))), acc);
                repeat (int'($urandom_range(3, 0)) == 3 ? 2 : 0) @(negedge clk);
            end
            wait_idle();
            chk_bit("R10", "idle after random block", idle, 1'b1);
            check_all("R2");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule